// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave side of a serial memory. It runs on a system clock, samples the SPI clock, chip select and data-in pins through synchronizers, and works in SPI mode 0. MOSI is taken on rising SCK and MISO changes after falling SCK. Each frame begins when chip select goes low and carries an 8-bit command, most significant bit first. The command set is: arm the write latch, read status, write status, read the array, and write the array. The array is a synchronous RAM of 4096 bytes, split into 32-byte pages.

Array writes first collect bytes in a page buffer. They reach the RAM only when chip select rises exactly on a byte boundary after at least one data byte. A programmable write-cycle timer then holds the busy flag. While it runs, the buffer is copied into the RAM one byte per clock. Reads stream out bytes from the whole array and wrap at the top address. Writes wrap inside the addressed page.

Top module: `spimem_ctrl`

## Requirements
- R1: After reset, `spi_miso_oe` is 0 and a status read returns 0x00. The status byte layout is bit 0 busy (WIP), bit 1 write latch (WEL), bits 7:2 user bits.
- R2: Command 0x06 sets WEL only when chip select rises after exactly 8 clocks. If even one extra clock comes before chip select rises, WEL stays clear. The command is also ignored while WIP is 1.
- R3: Command 0x05 shifts the status byte out on MISO, starting at the first falling SCK after its eighth bit.
- R4: Command 0x01 with WEL set, followed by exactly one data byte and then chip select rising, stores data bits 7:2 into the user bits. Data bits 1:0 are not stored. WEL clears when the write cycle ends.
- R5: Command 0x02 is followed by a 16-bit address, of which the low 12 bits are used, and then data bytes. The write commits to the array only if chip select rises after bit 0 of a data byte. It then starts the write cycle.
- R6: If chip select rises in the middle of a byte, or right after the address with no data byte, nothing is written and no write cycle starts. WEL stays set.
- R7: During a write, the byte index wraps from the last byte of the page to its first byte. Later bytes replace earlier ones.
- R8: Command 0x03 with a 16-bit address streams bytes from that address upward on MISO. It wraps from 0xFFF to 0x000.
- R9: After a committed write, WIP reads 1 for WR_CYCLES clocks. Status reads still work during that time. Array reads return no data and leave `spi_miso_oe` low.
- R10: Commands 0x02 and 0x01 have no effect while WEL is clear.
- R11: `spi_miso_oe` is 1 only during the data phase of a read or status read. It is 0 during the command and address phases, after chip select rises, and for any unknown command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for MISO; 0 means high impedance |

## Verification
Each pin passes two synchronizer stages and one edge register. A falling SCK therefore changes MISO and its enable three system clocks later, and the bench waits six clocks before it samples. A read-array byte is fetched from the RAM at the rising edge that completes the address. It is loaded at the next falling edge, several clocks later, so MISO carries valid data in the first data bit. The effect of a chip-select rise (WEL, WIP, user bits) is checked with a status read in a following frame. The end of WIP is checked after waiting more than WR_CYCLES clocks.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // status byte: user bits high, latch at bit 1, busy at bit 0
  function automatic logic [7:0] status_byte(input logic [5:0] user,
                                             input logic wel, input logic wip);
    return {user, wel, wip};
  endfunction
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= {STAGES{RST_VAL[g]}};
      else        sr <= {sr[STAGES-2:0], d[g]};
    end
    assign q[g] = sr[STAGES-1];
  end
endmodule

// File: rtl/spimem_wtimer.sv
module spimem_wtimer #(
  parameter int WR_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/spimem_ram.sv
module spimem_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    q <= mem[addr];
  end
endmodule

// File: rtl/spimem_pgbuf.sv
module spimem_pgbuf #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [PW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic          go,
  output logic          walking,
  output logic          mem_we,
  output logic [PW-1:0] mem_idx,
  output logic [7:0]    mem_wd
);
  localparam int PAGE = 1 << PW;
  logic [7:0]      bytes_q [PAGE];
  logic [PAGE-1:0] mask;
  logic [PW-1:0]   cidx;

  always_ff @(posedge clk) begin
    if (wr) bytes_q[widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask <= '0;
    else if (clr) mask <= '0;
    else if (wr)  mask[widx] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walking <= 1'b0;
      cidx    <= '0;
    end else if (go) begin
      walking <= 1'b1;
      cidx    <= '0;
    end else if (walking) begin
      cidx <= cidx + PW'(1);
      if (cidx == '1) walking <= 1'b0;
    end
  end

  assign mem_we  = walking & mask[cidx];
  assign mem_idx = cidx;
  assign mem_wd  = bytes_q[cidx];
endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
  import spimem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 20000,
  parameter int SYNC      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int HI_W = ADDR_W - 8;
  localparam int PG_W = ADDR_W - PAGE_W;

  function automatic logic [PAGE_W-1:0] page_next(input logic [PAGE_W-1:0] i);
    return i + PAGE_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] arr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // pin synchronizers: {cs_n, sck, mosi}
  logic [2:0] pins_l;
  spimem_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_cs_n, spi_sck, spi_mosi}), .q(pins_l));

  logic cs_l, sck_l, si_l, cs_prev, sck_prev;
  assign cs_l  = pins_l[2];
  assign sck_l = pins_l[1];
  assign si_l  = pins_l[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_l;
      sck_prev <= sck_l;
    end
  end

  logic cs_act, cs_fall, cs_rise, sck_rise_ev, sck_fall_ev;
  assign cs_act      = ~cs_l;
  assign cs_fall     = ~cs_l & cs_prev;
  assign cs_rise     = cs_l & ~cs_prev;
  assign sck_rise_ev = cs_act & sck_l & ~sck_prev;
  assign sck_fall_ev = cs_act & ~sck_l & sck_prev;

  // frame state
  logic [2:0]        bitc, byte_n;
  logic [6:0]        sh;
  logic [7:0]        opc, nb;
  logic [HI_W-1:0]   a_hi;
  logic [ADDR_W-1:0] full, rd_addr;
  logic [PG_W-1:0]   wr_page;
  logic [PAGE_W-1:0] wr_idx;
  logic [5:0]        wrsr_data, user_bits;
  logic              op_idle, op_wel, wr_ok, byte_done;
  logic              wel, wip, wr_done;

  assign nb        = {sh, si_l};
  assign full      = {a_hi, nb};
  assign byte_done = sck_rise_ev & (bitc == 3'd7);
  assign wr_ok     = op_idle & op_wel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitc <= '0; byte_n <= '0; opc <= '0; sh <= '0; a_hi <= '0;
      op_idle <= 1'b0; op_wel <= 1'b0; rd_addr <= '0;
      wr_page <= '0; wr_idx <= '0; wrsr_data <= '0;
    end else if (cs_fall) begin
      bitc <= '0; byte_n <= '0; opc <= '0;
    end else if (sck_rise_ev) begin
      sh   <= nb[6:0];
      bitc <= bitc + 3'd1;
      if (bitc == 3'd7) begin
        if (byte_n != 3'd4) byte_n <= byte_n + 3'd1;
        case (byte_n)
          3'd0: begin
            opc     <= nb;
            op_idle <= ~wip;
            op_wel  <= wel;
          end
          3'd1: begin
            a_hi <= nb[HI_W-1:0];
            if (opc == OP_WRSR) wrsr_data <= nb[7:2];
          end
          3'd2: begin
            if (opc == OP_READ && op_idle) rd_addr <= full;
            if (opc == OP_WRITE && wr_ok) {wr_page, wr_idx} <= full;
          end
          default: begin
            if (opc == OP_READ && op_idle) rd_addr <= arr_next(rd_addr);
            if (opc == OP_WRITE && wr_ok)  wr_idx  <= page_next(wr_idx);
          end
        endcase
      end
    end
  end

  // frame-end decisions
  logic wren_ev, wrsr_ev, wrarr_ev, commit_ev;
  assign wren_ev   = cs_rise & (opc == OP_WREN) & (byte_n == 3'd1) & (bitc == 3'd0) & ~wip;
  assign wrsr_ev   = cs_rise & (opc == OP_WRSR) & (byte_n == 3'd2) & (bitc == 3'd0) & wr_ok;
  assign wrarr_ev  = cs_rise & (opc == OP_WRITE) & (byte_n == 3'd4) & (bitc == 3'd0) & wr_ok;
  assign commit_ev = wrsr_ev | wrarr_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      user_bits <= '0;
    end else begin
      if (wr_done)      wel <= 1'b0;
      else if (wren_ev) wel <= 1'b1;
      if (wrsr_ev) user_bits <= wrsr_data;
    end
  end

  spimem_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_ev), .busy(wip), .done(wr_done));

  // page buffer and array
  logic              pb_wr, pb_clr, pb_walk, ram_we;
  logic [PAGE_W-1:0] pb_idx;
  logic [7:0]        pb_wd, ram_q;
  logic [ADDR_W-1:0] ram_addr;

  assign pb_wr  = byte_done & (byte_n >= 3'd3) & (opc == OP_WRITE) & wr_ok;
  assign pb_clr = byte_done & (byte_n == 3'd0) & (nb == OP_WRITE) & wel & ~wip;

  spimem_pgbuf #(.PW(PAGE_W)) u_pgbuf (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr(pb_wr), .widx(wr_idx),
    .wdata(nb), .go(wrarr_ev), .walking(pb_walk), .mem_we(ram_we),
    .mem_idx(pb_idx), .mem_wd(pb_wd));

  assign ram_addr = pb_walk ? {wr_page, pb_idx} : rd_addr;

  spimem_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wd(pb_wd), .q(ram_q));

  // transmit path
  logic       read_phase, tx_on;
  logic [7:0] tx_src, tx_sh;
  assign read_phase = ((opc == OP_READ) & (byte_n >= 3'd3) & op_idle) |
                      ((opc == OP_RDSR) & (byte_n >= 3'd1));
  assign tx_src     = (opc == OP_RDSR) ? status_byte(user_bits, wel, wip) : ram_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on <= 1'b0;
      tx_sh <= '0;
    end else if (cs_fall || cs_rise) begin
      tx_on <= 1'b0;
    end else if (sck_fall_ev && read_phase) begin
      tx_on <= 1'b1;
      tx_sh <= (bitc == 3'd0) ? tx_src : {tx_sh[6:0], 1'b0};
    end
  end

  assign spi_miso    = tx_on & tx_sh[7];
  assign spi_miso_oe = tx_on;
endmodule

// File: rtl/spimem_ctrl_chk.sv
module spimem_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_rise_ev,
  input logic sck_fall_ev,
  input logic commit_ev,
  input logic wren_ev,
  input logic wr_done,
  input logic wip,
  input logic wel,
  input logic mem_we,
  input logic miso_oe
);
  // R11
  oe_off_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_ev |=> !miso_oe);

  // R11
  oe_rise_on_sck_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(sck_fall_ev));

  // R9
  wip_start_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(commit_ev));

  // R5
  array_write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip);

  // R2
  wel_set_by_wren_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wren_ev));

  // R4
  wel_clear_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> $past(wr_done));
endmodule

bind spimem_ctrl spimem_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_rise_ev(cs_rise), .sck_fall_ev(sck_fall_ev),
  .commit_ev(commit_ev), .wren_ev(wren_ev), .wr_done(wr_done), .wip(wip),
  .wel(wel), .mem_we(ram_we), .miso_oe(spi_miso_oe));

// File: tb/spimem_ctrl_tb.sv
module spimem_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WRC        = 1500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spimem_ctrl #(.ADDR_W(12), .PAGE_W(5), .WR_CYCLES(WRC), .SYNC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe));

  // {addr[11:0], data[7:0]}
  localparam logic [19:0] VEC [0:5] = '{
    20'h000_11, 20'h010_A5, 20'h01F_3C, 20'h7E0_96, 20'hFFF_C3, 20'h123_5E};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic r, output logic oe);
    mosi = b;
    repeat (HALF) @(negedge clk);
    r  = miso;
    oe = miso_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_or);
    logic r, oe;
    oe_or = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(tx[i], r, oe);
      rx[i] = r;
      oe_or = oe_or | oe;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] rx;
    logic oe;
    byte_xfer(b, rx, oe);
  endtask

  task automatic wren();
    sel(); send(8'h06); desel();
  endtask

  task automatic rdsr(output logic [7:0] st, output logic oe_cmd);
    logic [7:0] rx;
    logic oe;
    sel();
    byte_xfer(8'h05, rx, oe_cmd);
    byte_xfer(8'h00, st, oe);
    desel();
  endtask

  task automatic write_hdr(input logic [11:0] a);
    sel(); send(8'h02); send({4'h0, a[11:8]}); send(a[7:0]);
  endtask

  task automatic read_hdr(input logic [11:0] a, output logic oe_hdr);
    logic [7:0] rx;
    logic o1, o2, o3;
    sel();
    byte_xfer(8'h03, rx, o1);
    byte_xfer({4'h0, a[11:8]}, rx, o2);
    byte_xfer(a[7:0], rx, o3);
    oe_hdr = o1 | o2 | o3;
  endtask

  task automatic read1(input logic [11:0] a, output logic [7:0] d);
    logic oe;
    read_hdr(a, oe);
    byte_xfer(8'h00, d, oe);
    desel();
  endtask

  task automatic wait_idle();
    repeat (WRC + 100) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d;
    logic oe, oe2, r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check("R1 oe after reset", miso_oe, 1'b0);
    rdsr(st, oe);
    check("R1 status after reset", st, 8'h00);
    // R11: no drive during command byte, none after deselect
    check("R11 oe during command", oe, 1'b0);
    check("R11 oe after deselect", miso_oe, 1'b0);

    // R2: one extra clock leaves the latch clear
    sel(); send(8'h06); bit_xfer(1'b0, r, oe); desel();
    rdsr(st, oe);
    check("R2 wren with 9 clocks", st, 8'h00);
    wren();
    rdsr(st, oe);
    check("R2 R3 wren 8 clocks", st, 8'h02);

    // R4 R9: status write, busy, array read blocked
    sel(); send(8'h01); send(8'hFF); desel();
    rdsr(st, oe);
    check("R9 R4 status during busy", st, 8'hFF);
    read_hdr(12'h000, oe);
    byte_xfer(8'h00, d, oe2);
    desel();
    check("R9 read while busy oe", {oe, oe2}, 2'b00);
    rdsr(st, oe);
    check("R9 still busy", st[0], 1'b1);
    wait_idle();
    rdsr(st, oe);
    check("R4 status after cycle", st, 8'hFC);

    // R5: table of single-byte writes read back
    for (int k = 0; k < 6; k++) begin
      wren();
      write_hdr(VEC[k][19:8]);
      send(VEC[k][7:0]);
      desel();
      wait_idle();
      read1(VEC[k][19:8], d);
      check($sformatf("R5 vector %0d", k), d, VEC[k][7:0]);
    end

    // R10: write with the latch clear has no effect
    write_hdr(12'h010); send(8'h5A); desel();
    rdsr(st, oe);
    check("R10 no cycle started", st, 8'hFC);
    wait_idle();
    read1(12'h010, d);
    check("R10 array unchanged", d, 8'hA5);
    sel(); send(8'h01); send(8'h00); desel();
    rdsr(st, oe);
    check("R10 status write ignored", st, 8'hFC);

    // R6: mid-byte abort and address-only frame
    wren();
    write_hdr(12'h010);
    for (int i = 0; i < 5; i++) bit_xfer(1'b1, r, oe);
    desel();
    rdsr(st, oe);
    check("R6 abort keeps latch, no busy", st, 8'hFE);
    write_hdr(12'h010); desel();
    rdsr(st, oe);
    check("R6 address-only frame", st, 8'hFE);
    read1(12'h010, d);
    check("R6 array unchanged", d, 8'hA5);

    // R7: 34 bytes from index 30 of page 0x020
    write_hdr(12'h03E);
    for (int k = 0; k < 34; k++) send(8'h40 + 8'(k));
    desel();
    wait_idle();
    read_hdr(12'h01F, oe);
    check("R11 oe during address", oe, 1'b0);
    byte_xfer(8'h00, d, oe);
    check("R7 previous page intact", d, 8'h3C);
    for (int j = 0; j < 32; j++) begin
      byte_xfer(8'h00, d, oe);
      check($sformatf("R7 page byte %0d", j), d, 8'h42 + 8'(j));
    end
    desel();
    rdsr(st, oe);
    check("R4 latch cleared after array write", st, 8'hFC);

    // R8: read wraps at the top of the array
    read_hdr(12'hFFF, oe);
    byte_xfer(8'h00, d, oe);
    check("R8 top byte", d, 8'hC3);
    check("R11 oe in data phase", oe, 1'b1);
    byte_xfer(8'h00, d, oe);
    check("R8 wrapped to zero", d, 8'h11);
    desel();
    check("R11 oe off after read", miso_oe, 1'b0);

    // R11: unknown command
    sel(); byte_xfer(8'hAB, d, oe); byte_xfer(8'h00, d, oe2); desel();
    check("R11 unknown command no drive", {oe, oe2}, 2'b00);
    rdsr(st, oe);
    check("R11 unknown command no effect", st, 8'hFC);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule